// File: doc/BRIEF.md
# Power-Good Strap Capture with Test Bypass

This block records the board's configuration straps once, at the moment the active-low power-good signal is first seen asserted, and then holds them for the rest of operation. Three frequency-select straps (C, B and A) pick the CPU clock frequency. A clock-request select strap decides whether two shared pins act as clock-request inputs or as extra clock outputs. A test-select indicator, which is the digital result of an external threshold comparison, arms test mode.

Power-good passes through a two-flop synchronizer. On the first synchronized low the straps are latched, and a `captured` flag rises. After that, further power-good or strap activity has no effect. The exception is test mode: there the frequency and clock-request straps keep flowing through to the outputs, one register stage late. Only reset re-arms the capture.

Top module: `strap_latch_top`

## Requirements
- R1: While reset is low, and after reset until capture, the outputs are: cpu_fs_code=000, freq_code=7, freq_bad=0, clkreq_as_out=0, test_mode=0, captured=0.
- R2: If pwrgd_n is low at a rising edge k, capture takes effect at edge k+2, and the outputs show it after that edge. At that point captured=1 and cpu_fs_code={fs_c,fs_b,fs_a} as sampled at edge k+2.
- R3: Once captured with test_mode=0, later changes on pwrgd_n, fs_a/b/c, clkreq_sel and test_sel leave every output unchanged.
- R4: freq_code decodes the captured {C,B,A} as 101→0 (100 MHz), 001→1 (133 MHz), 011→2 (166 MHz) and 010→3 (200 MHz). For these codes freq_bad=0.
- R5: Any other captured code gives freq_code=7 and freq_bad=1.
- R6: clkreq_as_out equals clkreq_sel as sampled at capture. A value of 0 means the pins act as request inputs and 1 means they act as clock outputs.
- R7: test_mode equals test_sel as sampled at capture. While test_mode=1, cpu_fs_code and clkreq_as_out follow the live straps with one cycle of register delay.
- R8: Only reset re-arms the capture. After reset the R1 defaults return, and a new power-good low captures fresh straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrgd_n | input | 1 | Active-low power-good, asynchronous to clk |
| fs_a | input | 1 | Frequency-select strap A |
| fs_b | input | 1 | Frequency-select strap B |
| fs_c | input | 1 | Frequency-select strap C |
| clkreq_sel | input | 1 | Pin-function strap: 0 request inputs, 1 clock outputs |
| test_sel | input | 1 | Digital result of the test-level threshold comparison |
| cpu_fs_code | output | 3 | Captured {C,B,A} |
| freq_code | output | 3 | Decoded frequency: 0..3 valid, 7 none or invalid |
| freq_bad | output | 1 | Captured code is outside the table |
| clkreq_as_out | output | 1 | Shared pins act as clock outputs |
| test_mode | output | 1 | Test mode latched |
| captured | output | 1 | One-shot has fired |

## Verification
A one-shot that re-fires, or a hold register that stays open outside test mode, shows at the ports as soon as the edge after any strap or power-good change made after capture. The stimulus deliberately makes such changes. A wrong synchronizer depth shifts the rise of `captured` away from edge k+2, and the bench samples exactly there. A decode fault appears on `freq_code`/`freq_bad` in the same cycle as capture, and the bench covers all eight strap codes.

// File: rtl/strap_pkg.sv
// Package: shared widths, the decoded frequency type and the strap decode.
// Assumes straps are ordered {C,B,A} with A in bit 0.
package strap_pkg;
    localparam int FS_W = 3;

    typedef enum logic [2:0] {
        FREQ_100  = 3'd0,
        FREQ_133  = 3'd1,
        FREQ_166  = 3'd2,
        FREQ_200  = 3'd3,
        FREQ_NONE = 3'd7
    } cpu_freq_e;

    // Maps a strap code to its frequency; codes outside the table give FREQ_NONE.
    function automatic cpu_freq_e decode_fs(input logic [FS_W-1:0] code);
        case (code)
            3'b101:  return FREQ_100;
            3'b001:  return FREQ_133;
            3'b011:  return FREQ_166;
            3'b010:  return FREQ_200;
            default: return FREQ_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pg_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level. Reset loads the inactive value RST_VAL.
module pg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the level through the chain one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/strap_freq_decode.sv
// Module: pure combinational decode of the held strap code.
// Assumes the code is already registered, so its output is glitch-free.
module strap_freq_decode
    import strap_pkg::*;
(
    input  logic [FS_W-1:0] code,
    output cpu_freq_e       freq,
    output logic            valid
);
    // Table lookup plus a validity flag.
    always_comb begin
        freq  = decode_fs(code);
        valid = (freq != FREQ_NONE);
    end
endmodule

// File: rtl/strap_capture.sv
// Module: one-shot capture of the straps on the first synchronized power-good low.
// Assumes pg_n_sync is synchronous to clk. Only rst_n re-arms the one-shot.
module strap_capture
    import strap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_n_sync,
    input  logic [FS_W-1:0] fs_live,
    input  logic            clkreq_live,
    input  logic            test_live,
    output logic [FS_W-1:0] fs_q,
    output logic            clkreq_q,
    output logic            test_q,
    output logic            cap_q
);
    // Fire once, then hold; in test mode keep reloading the straps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q     <= '0;
            clkreq_q <= 1'b0;
            test_q   <= 1'b0;
            cap_q    <= 1'b0;
        end else if (!cap_q) begin
            if (!pg_n_sync) begin
                cap_q    <= 1'b1;
                fs_q     <= fs_live;
                clkreq_q <= clkreq_live;
                test_q   <= test_live;
            end
        end else if (test_q) begin
            fs_q     <= fs_live;
            clkreq_q <= clkreq_live;
        end
    end
endmodule

// File: rtl/strap_latch_top.sv
// Module: top of the strap capture. It chains sync, capture and decode.
// Assumes straps are stable around the capture edge. Decoded outputs stay neutral until capture.
module strap_latch_top
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrgd_n,
    input  logic       fs_a,
    input  logic       fs_b,
    input  logic       fs_c,
    input  logic       clkreq_sel,
    input  logic       test_sel,
    output logic [2:0] cpu_fs_code,
    output logic [2:0] freq_code,
    output logic       freq_bad,
    output logic       clkreq_as_out,
    output logic       test_mode,
    output logic       captured
);
    logic            pg_n_s;
    logic [FS_W-1:0] fs_q;
    cpu_freq_e       freq;
    logic            freq_ok;

    pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwrgd_n),
        .dout (pg_n_s)
    );

    strap_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pg_n_sync  (pg_n_s),
        .fs_live    ({fs_c, fs_b, fs_a}),
        .clkreq_live(clkreq_sel),
        .test_live  (test_sel),
        .fs_q       (fs_q),
        .clkreq_q   (clkreq_as_out),
        .test_q     (test_mode),
        .cap_q      (captured)
    );

    strap_freq_decode u_dec (
        .code (fs_q),
        .freq (freq),
        .valid(freq_ok)
    );

    // Hide the decode until capture, then flag codes outside the table.
    always_comb begin
        cpu_fs_code = fs_q;
        freq_code   = captured ? freq : FREQ_NONE;
        freq_bad    = captured & ~freq_ok;
    end
endmodule

// File: rtl/strap_latch_chk.sv
// Module: assertion checker bound to strap_latch_top.
module strap_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwrgd_n,
    input logic [2:0] fs_live,
    input logic       clkreq_sel,
    input logic [2:0] cpu_fs_code,
    input logic [2:0] freq_code,
    input logic       freq_bad,
    input logic       clkreq_as_out,
    input logic       test_mode,
    input logic       captured
);
    p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !captured |-> (cpu_fs_code == 3'b000 && freq_code == 3'd7 && !freq_bad
                       && !clkreq_as_out && !test_mode));

    p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(captured) |-> ($past(pwrgd_n, 3) == 1'b0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && !test_mode) |=> (captured && $stable(cpu_fs_code)
                                      && $stable(clkreq_as_out) && !test_mode));

    p_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && cpu_fs_code == 3'b010) |-> (freq_code == 3'd3 && !freq_bad));

    p_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freq_bad |-> (captured && freq_code == 3'd7));

    p_test_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && test_mode) |=> (cpu_fs_code == $past(fs_live)
                                     && clkreq_as_out == $past(clkreq_sel)));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        captured |=> captured);
endmodule

bind strap_latch_top strap_latch_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwrgd_n      (pwrgd_n),
    .fs_live      ({fs_c, fs_b, fs_a}),
    .clkreq_sel   (clkreq_sel),
    .cpu_fs_code  (cpu_fs_code),
    .freq_code    (freq_code),
    .freq_bad     (freq_bad),
    .clkreq_as_out(clkreq_as_out),
    .test_mode    (test_mode),
    .captured     (captured)
);

// File: tb/tb_strap_latch_top.sv
module tb_strap_latch_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrgd_n = 1'b1;
    logic fs_a = 1'b0, fs_b = 1'b0, fs_c = 1'b0;
    logic clkreq_sel = 1'b0, test_sel = 1'b0;
    logic [2:0] cpu_fs_code, freq_code;
    logic freq_bad, clkreq_as_out, test_mode, captured;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    strap_latch_top dut (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n),
        .fs_a(fs_a), .fs_b(fs_b), .fs_c(fs_c),
        .clkreq_sel(clkreq_sel), .test_sel(test_sel),
        .cpu_fs_code(cpu_fs_code), .freq_code(freq_code), .freq_bad(freq_bad),
        .clkreq_as_out(clkreq_as_out), .test_mode(test_mode), .captured(captured)
    );

    // Vector: [7:5] straps {C,B,A}, [4] clkreq_sel, [3:1] expected freq_code, [0] expected freq_bad.
    localparam logic [7:0] VEC [8] = '{
        {3'b101, 1'b0, 3'd0, 1'b0},
        {3'b001, 1'b1, 3'd1, 1'b0},
        {3'b011, 1'b0, 3'd2, 1'b0},
        {3'b010, 1'b1, 3'd3, 1'b0},
        {3'b000, 1'b0, 3'd7, 1'b1},
        {3'b111, 1'b1, 3'd7, 1'b1},
        {3'b100, 1'b0, 3'd7, 1'b1},
        {3'b110, 1'b1, 3'd7, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pwrgd_n = 1'b1;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic set_straps(input logic [2:0] cba, input logic cr, input logic ts);
        {fs_c, fs_b, fs_a} = cba; clkreq_sel = cr; test_sel = ts;
    endtask

    task automatic check_defaults(input string tag);
        check({tag, " captured"}, captured, 0);
        check({tag, " cpu_fs_code"}, cpu_fs_code, 0);
        check({tag, " freq_code"}, freq_code, 7);
        check({tag, " freq_bad"}, freq_bad, 0);
        check({tag, " clkreq_as_out"}, clkreq_as_out, 0);
        check({tag, " test_mode"}, test_mode, 0);
    endtask

    initial begin
        #1;
        cyc(1);
        check_defaults("R1 in reset");
        rst_n = 1'b1;

        // Table walk: one capture per vector (R4, R5, R6, R2).
        foreach (VEC[i]) begin
            do_reset();
            set_straps(VEC[i][7:5], VEC[i][4], 1'b0);
            cyc(1);
            check_defaults("R1 armed");
            pwrgd_n = 1'b0;
            cyc(2);
            check("R2 not yet captured", captured, 0);
            cyc(1);
            check("R2 captured", captured, 1);
            check("R2 cpu_fs_code", cpu_fs_code, VEC[i][7:5]);
            check("R4/R5 freq_code", freq_code, VEC[i][3:1]);
            check("R5 freq_bad", freq_bad, VEC[i][0]);
            check("R6 clkreq_as_out", clkreq_as_out, VEC[i][4]);
            check("R7 test_mode off", test_mode, 0);
        end

        // R3: after a normal capture of 011, all later activity is ignored.
        do_reset();
        set_straps(3'b011, 1'b1, 1'b0);
        pwrgd_n = 1'b0;
        cyc(3);
        set_straps(3'b101, 1'b0, 1'b1);
        pwrgd_n = 1'b1;
        cyc(3);
        pwrgd_n = 1'b0;
        cyc(4);
        check("R3 code held", cpu_fs_code, 3'b011);
        check("R3 freq held", freq_code, 2);
        check("R3 clkreq held", clkreq_as_out, 1);
        check("R3 test not entered", test_mode, 0);
        check("R3 still captured", captured, 1);

        // R7: test mode, where the straps stay transparent.
        do_reset();
        set_straps(3'b001, 1'b0, 1'b1);
        pwrgd_n = 1'b0;
        cyc(3);
        check("R7 test_mode", test_mode, 1);
        check("R7 initial code", cpu_fs_code, 3'b001);
        set_straps(3'b010, 1'b1, 1'b0);
        cyc(1);
        check("R7 code follows", cpu_fs_code, 3'b010);
        check("R7 freq follows", freq_code, 3);
        check("R7 clkreq follows", clkreq_as_out, 1);
        check("R7 test stays", test_mode, 1);
        set_straps(3'b111, 1'b0, 1'b0);
        cyc(1);
        check("R7 invalid follows", freq_bad, 1);

        // R8: reset re-arms the one-shot, and a new capture takes fresh straps.
        rst_n = 1'b0;
        cyc(1);
        check_defaults("R8 reset");
        rst_n = 1'b1;
        pwrgd_n = 1'b1;
        set_straps(3'b101, 1'b1, 1'b0);
        cyc(2);
        check_defaults("R8 rearmed");
        pwrgd_n = 1'b0;
        cyc(3);
        check("R8 recapture", captured, 1);
        check("R8 new code", cpu_fs_code, 3'b101);
        check("R8 new freq", freq_code, 0);
        check("R8 no test", test_mode, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule